// File: doc/BRIEF.md
# LCD Common Row Scan Register

This block scans the common (row) electrodes of a dot-matrix liquid crystal panel. A chain of stages, one per row, holds a single select bit. On every falling edge of the line clock the bit moves one row further. Each stage is turned into a two-bit drive-level code. The code depends on whether the row is selected and on the AC-inversion phase. An analog switch bank outside this block uses the code to pick one of four voltages.

The chain has two end pins, A next to output 0 and B next to output N-1. A direction input decides which end takes the scan bit in and which end passes it to a cascaded device, together with the output enable for that end. In slave mode the scan bit comes in on the input end pin. In master mode the block starts its own scan: it feeds a new bit into the first stage whenever the chain would otherwise be empty. This gives a self-repeating frame of N lines.

Top module: `lcd_com_scan`

## Requirements
- R1: An active-low reset clears every stage, so that every output shows an unselected code (3 while `ac_phase` is 0, 2 while it is 1).
- R2: Each output `level_code[2*i+1:2*i]` is 0 for a selected row with `ac_phase`=1, 1 for a selected row with `ac_phase`=0, 2 for an unselected row with `ac_phase`=1 and 3 for an unselected row with `ac_phase`=0.
- R3: With `dir_fwd`=1 and slave mode, each falling edge of `line_clk` loads `pin_a_i` into output 0 and moves every output i to output i+1.
- R4: With `dir_fwd`=0 and slave mode, each falling edge loads `pin_b_i` into output N-1 and moves every output i to output i-1.
- R5: With `dir_fwd`=1 only `pin_b_oe` is high, and with `dir_fwd`=0 only `pin_a_oe` is high.
- R6: The cascade pin at the output end (`pin_b_o` for `dir_fwd`=1, `pin_a_o` for `dir_fwd`=0) carries the last stage. A bit entered at the input end is high on it after exactly N falling edges and is low again after the next one. The other pin's output is 0.
- R7: In master mode (`master_en`=1) the first stage is loaded with 1 exactly when every stage except the last is clear. After reset the selected row is therefore the first row after edge 1 and steps once per edge, which gives a frame period of N edges.
- R8: In master mode the input end pin has no effect: with it held high, exactly one row is selected after every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| line_clk | input | 1 | Line clock; the stages advance on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_fwd | input | 1 | 1: scan from output 0 upward; 0: from output N-1 downward |
| master_en | input | 1 | 1: self-generated scan; 0: scan bit from the end pin |
| ac_phase | input | 1 | AC-inversion phase used for the level codes |
| pin_a_i | input | 1 | End pin A input (scan in when `dir_fwd`=1) |
| pin_a_o | output | 1 | End pin A output (cascade out when `dir_fwd`=0) |
| pin_a_oe | output | 1 | End pin A output enable |
| pin_b_i | input | 1 | End pin B input (scan in when `dir_fwd`=0) |
| pin_b_o | output | 1 | End pin B output (cascade out when `dir_fwd`=1) |
| pin_b_oe | output | 1 | End pin B output enable |
| level_code | output | 2*N | Two-bit drive-level code per row, row i in bits [2i+1:2i] |

## Verification
The hardest case to reach is the far end of the chain. A bit must travel all N stages before it appears on the cascade pin, and in master mode it then wraps back to the first stage on the same edge. The stimulus therefore enters one bit and clocks N+1 edges in each direction, checking the one selected row after every edge. Master mode is then run past two full frames with the input pin held high, so that a stray injection would show up as a second selected row.

// File: rtl/lcd_com_pkg.sv
`timescale 1ns/1ps
package lcd_com_pkg;

    typedef enum logic [1:0] {
        LVL_SEL_POS  = 2'd0,
        LVL_SEL_NEG  = 2'd1,
        LVL_IDLE_POS = 2'd2,
        LVL_IDLE_NEG = 2'd3
    } lcd_level_e;

    function automatic lcd_level_e level_of(input logic sel, input logic ac);
        lcd_level_e lv;
        case ({sel, ac})
            2'b11:   lv = LVL_SEL_POS;
            2'b10:   lv = LVL_SEL_NEG;
            2'b01:   lv = LVL_IDLE_POS;
            default: lv = LVL_IDLE_NEG;
        endcase
        return lv;
    endfunction

endpackage

// File: rtl/lcd_com_end_port.sv
`timescale 1ns/1ps
module lcd_com_end_port #(
    parameter int N = 64
) (
    input  logic         dir_fwd,
    input  logic         master_en,
    input  logic         pin_a_i,
    input  logic         pin_b_i,
    input  logic [N-1:0] stages,
    output logic         feed_bit,
    output logic         pin_a_o,
    output logic         pin_a_oe,
    output logic         pin_b_o,
    output logic         pin_b_oe
);
    logic chain_idle;

    always_comb begin
        if (dir_fwd) begin
            chain_idle = (stages[N-2:0] == '0);
        end else begin
            chain_idle = (stages[N-1:1] == '0);
        end

        if (master_en) begin
            feed_bit = chain_idle;
        end else if (dir_fwd) begin
            feed_bit = pin_a_i;
        end else begin
            feed_bit = pin_b_i;
        end

        pin_a_oe = !dir_fwd;
        pin_b_oe = dir_fwd;
        pin_a_o  = dir_fwd ? 1'b0 : stages[0];
        pin_b_o  = dir_fwd ? stages[N-1] : 1'b0;
    end
endmodule

// File: rtl/lcd_com_shift_core.sv
`timescale 1ns/1ps
module lcd_com_shift_core #(
    parameter int N = 64
) (
    input  logic         line_clk,
    input  logic         rst_n,
    input  logic         dir_fwd,
    input  logic         feed_bit,
    output logic [N-1:0] stages
);
    typedef struct packed {
        logic [N-1:0] row;
    } chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        if (dir_fwd) begin
            chain_d.row = {chain_q.row[N-2:0], feed_bit};
        end else begin
            chain_d.row = {feed_bit, chain_q.row[N-1:1]};
        end
    end

    always_ff @(negedge line_clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign stages = chain_q.row;
endmodule

// File: rtl/lcd_com_level_enc.sv
`timescale 1ns/1ps
module lcd_com_level_enc #(
    parameter int N = 64
) (
    input  logic [N-1:0]   stages,
    input  logic           ac_phase,
    output logic [2*N-1:0] level_code
);
    import lcd_com_pkg::*;

    for (genvar i = 0; i < N; i++) begin : g_row
        lcd_level_e lv;
        always_comb lv = level_of(stages[i], ac_phase);
        assign level_code[2*i +: 2] = lv;
    end
endmodule

// File: rtl/lcd_com_scan.sv
`timescale 1ns/1ps
module lcd_com_scan #(
    parameter int N = 64
) (
    input  logic           line_clk,
    input  logic           rst_n,
    input  logic           dir_fwd,
    input  logic           master_en,
    input  logic           ac_phase,
    input  logic           pin_a_i,
    output logic           pin_a_o,
    output logic           pin_a_oe,
    input  logic           pin_b_i,
    output logic           pin_b_o,
    output logic           pin_b_oe,
    output logic [2*N-1:0] level_code
);
    logic [N-1:0] stages;
    logic         feed_bit;

    lcd_com_end_port #(.N(N)) port_i (
        .dir_fwd  (dir_fwd),
        .master_en(master_en),
        .pin_a_i  (pin_a_i),
        .pin_b_i  (pin_b_i),
        .stages   (stages),
        .feed_bit (feed_bit),
        .pin_a_o  (pin_a_o),
        .pin_a_oe (pin_a_oe),
        .pin_b_o  (pin_b_o),
        .pin_b_oe (pin_b_oe)
    );

    lcd_com_shift_core #(.N(N)) core_i (
        .line_clk(line_clk),
        .rst_n   (rst_n),
        .dir_fwd (dir_fwd),
        .feed_bit(feed_bit),
        .stages  (stages)
    );

    lcd_com_level_enc #(.N(N)) enc_i (
        .stages    (stages),
        .ac_phase  (ac_phase),
        .level_code(level_code)
    );
endmodule

// File: rtl/lcd_com_scan_chk.sv
`timescale 1ns/1ps
module lcd_com_scan_chk #(
    parameter int N = 64
) (
    input logic           line_clk,
    input logic           rst_n,
    input logic           dir_fwd,
    input logic           master_en,
    input logic           ac_phase,
    input logic           pin_a_i,
    input logic           pin_a_o,
    input logic           pin_a_oe,
    input logic           pin_b_i,
    input logic           pin_b_o,
    input logic           pin_b_oe,
    input logic [2*N-1:0] level_code
);
    logic [N-1:0] sel_w;
    logic [N-1:0] lo_w;

    for (genvar i = 0; i < N; i++) begin : g_split
        assign sel_w[i] = ~level_code[2*i+1];
        assign lo_w[i]  = level_code[2*i];
    end

    // R2: low code bit follows the inverted AC phase on every row
    assert_ac_bit_R2: assert property (@(negedge line_clk) disable iff (!rst_n)
        lo_w == {N{~ac_phase}});

    // R3: forward slave shift
    assert_fwd_shift_R3: assert property (@(negedge line_clk) disable iff (!rst_n)
        (dir_fwd && !master_en) |=>
        (sel_w[N-1:1] == $past(sel_w[N-2:0])) && (sel_w[0] == $past(pin_a_i)));

    // R4: reverse slave shift
    assert_rev_shift_R4: assert property (@(negedge line_clk) disable iff (!rst_n)
        (!dir_fwd && !master_en) |=>
        (sel_w[N-2:0] == $past(sel_w[N-1:1])) && (sel_w[N-1] == $past(pin_b_i)));

    // R5: enable only on the output end
    assert_oe_fwd_R5: assert property (@(negedge line_clk) disable iff (!rst_n)
        dir_fwd |-> (pin_b_oe && !pin_a_oe));
    assert_oe_rev_R5: assert property (@(negedge line_clk) disable iff (!rst_n)
        !dir_fwd |-> (pin_a_oe && !pin_b_oe));

    // R6: cascade pins carry the last stage
    assert_cascade_fwd_R6: assert property (@(negedge line_clk) disable iff (!rst_n)
        dir_fwd |-> (pin_b_o == sel_w[N-1]) && !pin_a_o);
    assert_cascade_rev_R6: assert property (@(negedge line_clk) disable iff (!rst_n)
        !dir_fwd |-> (pin_a_o == sel_w[0]) && !pin_b_o);

    // R7: master self-feed into the first stage
    assert_master_fwd_R7: assert property (@(negedge line_clk) disable iff (!rst_n)
        (dir_fwd && master_en) |=> (sel_w[0] == ($past(sel_w[N-2:0]) == '0)));
    assert_master_rev_R7: assert property (@(negedge line_clk) disable iff (!rst_n)
        (!dir_fwd && master_en) |=> (sel_w[N-1] == ($past(sel_w[N-1:1]) == '0)));
endmodule

bind lcd_com_scan lcd_com_scan_chk #(.N(N)) chk_i (
    .line_clk  (line_clk),
    .rst_n     (rst_n),
    .dir_fwd   (dir_fwd),
    .master_en (master_en),
    .ac_phase  (ac_phase),
    .pin_a_i   (pin_a_i),
    .pin_a_o   (pin_a_o),
    .pin_a_oe  (pin_a_oe),
    .pin_b_i   (pin_b_i),
    .pin_b_o   (pin_b_o),
    .pin_b_oe  (pin_b_oe),
    .level_code(level_code)
);

// File: tb/lcd_com_scan_tb_top.sv
`timescale 1ns/1ps
module lcd_com_scan_tb_top;
    localparam int N = 64;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           dir_fwd = 1'b1;
    logic           master_en = 1'b0;
    logic           ac_phase = 1'b0;
    logic           pin_a_i = 1'b0;
    logic           pin_b_i = 1'b0;
    logic           pin_a_o, pin_a_oe, pin_b_o, pin_b_oe;
    logic [2*N-1:0] level_code;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    lcd_com_scan #(.N(N)) dut_i (
        .line_clk  (clk),
        .rst_n     (rst_n),
        .dir_fwd   (dir_fwd),
        .master_en (master_en),
        .ac_phase  (ac_phase),
        .pin_a_i   (pin_a_i),
        .pin_a_o   (pin_a_o),
        .pin_a_oe  (pin_a_oe),
        .pin_b_i   (pin_b_i),
        .pin_b_o   (pin_b_o),
        .pin_b_oe  (pin_b_oe),
        .level_code(level_code)
    );

    // {ac, din, expected code row 0, expected code row 1}; forward slave
    localparam logic [5:0] VEC [8] = '{
        {1'b0, 1'b1, 2'd1, 2'd3},
        {1'b1, 1'b0, 2'd2, 2'd0},
        {1'b0, 1'b0, 2'd3, 2'd3},
        {1'b1, 1'b1, 2'd0, 2'd2},
        {1'b1, 1'b1, 2'd0, 2'd0},
        {1'b0, 1'b0, 2'd3, 2'd1},
        {1'b0, 1'b1, 2'd1, 2'd3},
        {1'b1, 1'b0, 2'd2, 2'd0}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int code_at(input int idx);
        return int'(level_code[2*idx +: 2]);
    endfunction

    function automatic int sel_count();
        int c = 0;
        for (int i = 0; i < N; i++) if (level_code[2*i+1] == 1'b0) c++;
        return c;
    endfunction

    function automatic int sel_first();
        for (int i = 0; i < N; i++) if (level_code[2*i+1] == 1'b0) return i;
        return -1;
    endfunction

    task automatic shift_once();
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        #1 rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // Reset state: R1, R5
        do_reset();
        for (int i = 0; i < N; i++) begin
            if (code_at(i) != 3) check(0, "R1", "reset code", code_at(i), 3);
        end
        check(sel_count() == 0, "R1", "selected after reset", sel_count(), 0);
        ac_phase = 1'b1;
        #1 check(code_at(N/2) == 2, "R1", "idle code with ac=1", code_at(N/2), 2);
        check(pin_b_oe && !pin_a_oe, "R5", "fwd enables", {pin_a_oe, pin_b_oe}, 1);

        // Table: R2 with R3 row loading
        for (int v = 0; v < 8; v++) begin
            ac_phase = VEC[v][5];
            pin_a_i  = VEC[v][4];
            shift_once();
            check(code_at(0) == int'(VEC[v][3:2]), "R2", "row0 code", code_at(0), int'(VEC[v][3:2]));
            check(code_at(1) == int'(VEC[v][1:0]), "R2", "row1 code", code_at(1), int'(VEC[v][1:0]));
        end

        // Forward single bit walk: R3, R6
        ac_phase = 1'b0;
        pin_a_i  = 1'b0;
        do_reset();
        pin_a_i = 1'b1;
        for (int k = 1; k <= N; k++) begin
            shift_once();
            pin_a_i = 1'b0;
            check(sel_count() == 1 && sel_first() == k - 1, "R3", "fwd selected row",
                  sel_first(), k - 1);
            if (k == N - 1) check(pin_b_o == 1'b0, "R6", "fwd cascade early", pin_b_o, 0);
        end
        check(pin_b_o == 1'b1, "R6", "fwd cascade after N", pin_b_o, 1);
        check(pin_a_o == 1'b0, "R6", "fwd idle pin a", pin_a_o, 0);
        shift_once();
        check(pin_b_o == 1'b0, "R6", "fwd cascade after N+1", pin_b_o, 0);
        check(sel_count() == 0, "R6", "fwd chain empty", sel_count(), 0);

        // Reverse single bit walk: R4, R5, R6
        dir_fwd = 1'b0;
        do_reset();
        check(pin_a_oe && !pin_b_oe, "R5", "rev enables", {pin_a_oe, pin_b_oe}, 2);
        pin_b_i = 1'b1;
        for (int k = 1; k <= N; k++) begin
            shift_once();
            pin_b_i = 1'b0;
            check(sel_count() == 1 && sel_first() == N - k, "R4", "rev selected row",
                  sel_first(), N - k);
        end
        check(pin_a_o == 1'b1, "R6", "rev cascade after N", pin_a_o, 1);
        check(pin_b_o == 1'b0, "R6", "rev idle pin b", pin_b_o, 0);
        shift_once();
        check(pin_a_o == 1'b0, "R6", "rev cascade after N+1", pin_a_o, 0);

        // Master forward, input pin held high: R7, R8
        dir_fwd   = 1'b1;
        master_en = 1'b1;
        pin_a_i   = 1'b1;
        do_reset();
        for (int k = 1; k <= 2 * N + 3; k++) begin
            shift_once();
            check(sel_count() == 1, "R8", "master fwd one row", sel_count(), 1);
            check(sel_first() == (k - 1) % N, "R7", "master fwd row", sel_first(), (k - 1) % N);
        end

        // Master reverse, input pin held high: R7, R8
        dir_fwd = 1'b0;
        pin_b_i = 1'b1;
        do_reset();
        for (int k = 1; k <= N + 3; k++) begin
            shift_once();
            check(sel_count() == 1, "R8", "master rev one row", sel_count(), 1);
            check(sel_first() == N - 1 - ((k - 1) % N), "R7", "master rev row",
                  sel_first(), N - 1 - ((k - 1) % N));
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule